// File: doc/BRIEF.md
# Watchdog Fail-Safe Mode Controller

This block supervises a host processor with a watchdog timer and drives a bank of twelve switch enables: four high-side switches (indices 0 to 3) and eight low-side switches (indices 4 to 11). The watchdog arms when either of two control inputs, a wake line and a control-reset line, rises. From then on the host must service it, either by toggling a dedicated watchdog pin or by flipping the watchdog bit from one serial command frame to the next. If no service arrives within the selected timeout, the block latches a fail-safe state. In that state high-side switches 0 and 2 are forced on and every other switch is forced off.

The two control inputs also decide the operating mode. With both low the block sleeps, with only wake high it holds every switch off, and with control-reset high it passes the requested switch pattern through. A fail-safe state records which control inputs were high when the timer ran out. It is left only when all of those inputs have gone low. A disable input keeps the timer from ever expiring. The timeout is a base count of clock ticks, which a configuration strobe can divide by 2, 4 or 8.

Top module: `wdog_failsafe_ctrl`

## Requirements
- R1: After reset, with both control inputs low, the mode is sleep (code 0), all switch enables are 0 and no fail-safe is latched.
- R2: A 0-to-1 change on `wake_i` or `ctl_rst_i` arms the watchdog and restarts its timer. With no service, fail-safe (mode code 3) shows exactly `limit` clock edges after the edge that sampled the rising input. The default `limit` is TIMEOUT.
- R3: Every change of `wd_pin_i`, rising or falling, restarts the timer. The pin passes two synchronising flip-flops, so a change present at edge k restarts the count at edge k+2.
- R4: A frame strobed by `cmd_valid_i` restarts the timer only if its `cmd_wd_bit_i` differs from the bit of the previous frame. The stored bit is 0 after reset. A frame carrying the same bit has no effect.
- R5: A pulse on `div_load_i` loads `div_sel_i`, which sets `limit` to TIMEOUT >> `div_sel_i` (TIMEOUT, /2, /4, /8). The same pulse restarts the timer.
- R6: While fail-safe is latched, `sw_en_o` equals 12'h005 (bit i is switch i; bits 0 and 2 on, all others off), whatever `sw_req_i` holds.
- R7: Fail-safe is left at the edge after every control input that was high at expiry has gone low. Inputs that were low at expiry do not matter, and rising edges during fail-safe are ignored. On leaving, the timer restarts if either input is high.
- R8: Mode code: 3 when fail-safe is latched, else 2 when `ctl_rst_i` is 1, else 1 when only `wake_i` is 1, else 0.
- R9: In mode 2, `sw_en_o` equals `sw_req_i`. In modes 0 and 1, `sw_en_o` is all zero.
- R10: While `fs_disable_i` is 1, the timer is held clear and fail-safe is never entered. When it goes low, counting starts over.
- R11: A service event in the same cycle in which the timer would expire takes priority. No fail-safe is entered and a full new timeout begins.
- R12: With both control inputs low, the watchdog is disarmed and its timer cleared, so no amount of time in sleep leads to fail-safe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one oscillator tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wake control input |
| ctl_rst_i | input | 1 | Control-reset input (high = run) |
| wd_pin_i | input | 1 | Dedicated watchdog service pin, asynchronous |
| cmd_valid_i | input | 1 | Strobe marking a received serial command frame |
| cmd_wd_bit_i | input | 1 | Watchdog bit of the strobed frame |
| div_load_i | input | 1 | Strobe loading the timeout divider setting |
| div_sel_i | input | SEL_W | Divider setting: timeout = TIMEOUT >> value |
| fs_disable_i | input | 1 | 1 disables watchdog expiry |
| sw_req_i | input | 12 | Requested switch enables from configuration |
| sw_en_o | output | 12 | Switch enables actually driven |
| mode_o | output | 2 | Mode code (0 sleep, 1 default, 2 normal, 3 fail-safe) |

## Verification
Two events can fall in the same cycle: the timer reaching its last count, which would latch fail-safe, and a service that restarts it. The bench arms the watchdog and sends a flipped serial frame so that it is sampled on exactly the edge where expiry would land. It then expects normal mode and a full fresh timeout, with fail-safe appearing only `limit` edges later. Random service gaps on either side of the limit, including gaps equal to it and one short of it, bracket the same boundary. A frame sent one cycle too late must leave the latched fail-safe untouched.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

    localparam int unsigned NUM_HS = 4;
    localparam int unsigned NUM_LS = 8;
    localparam int unsigned NUM_SW = NUM_HS + NUM_LS;

    typedef enum logic [1:0] {
        MODE_SLEEP    = 2'd0,
        MODE_DEFAULT  = 2'd1,
        MODE_NORMAL   = 2'd2,
        MODE_FAILSAFE = 2'd3
    } wfs_mode_e;

    // High-side switches 0 and 2 on, every other switch off
    function automatic logic [NUM_SW-1:0] failsafe_pattern();
        logic [NUM_SW-1:0] pat;
        for (int i = 0; i < NUM_SW; i++) begin
            pat[i] = (i == 0) || (i == 2);
        end
        return pat;
    endfunction

endpackage

// File: rtl/wfs_toggle_sync.sv
module wfs_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic toggle_o
);

    // sh[0..STAGES-1] synchroniser chain, sh[STAGES] previous synced value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign toggle_o = sh_q[STAGES-1] ^ sh_q[STAGES];

    // R3: a detected change is a single-cycle pulse unless the pin moved again
    toggle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |=> (sh_q[STAGES] == $past(sh_q[STAGES-1])));

endmodule

// File: rtl/wfs_timer.sv
module wfs_timer #(
    parameter int unsigned TIMEOUT = 32,
    parameter int unsigned SEL_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic             div_load_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             expire_o
);

    localparam int unsigned CNT_W   = $clog2(TIMEOUT + 1);
    localparam int unsigned NUM_DIV = 1 << SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] div;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] lim_tab [NUM_DIV];
    logic [CNT_W-1:0] limit;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'(TIMEOUT >> g);
    end

    assign limit = lim_tab[st_q.div];

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (div_load_i) st_d.div = div_sel_i;
        if (clear_i || restart_i || div_load_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            if (st_q.cnt == limit - CNT_W'(1)) begin
                expire_o = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < limit);

    // R3
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdog_failsafe_ctrl.sv
module wdog_failsafe_ctrl
    import wfs_pkg::*;
#(
    parameter int unsigned TIMEOUT     = 32,
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              ctl_rst_i,
    input  logic              wd_pin_i,
    input  logic              cmd_valid_i,
    input  logic              cmd_wd_bit_i,
    input  logic              div_load_i,
    input  logic [SEL_W-1:0]  div_sel_i,
    input  logic              fs_disable_i,
    input  logic [NUM_SW-1:0] sw_req_i,
    output logic [NUM_SW-1:0] sw_en_o,
    output logic [1:0]        mode_o
);

    localparam logic [NUM_SW-1:0] FS_PAT = failsafe_pattern();

    typedef struct packed {
        logic armed;
        logic fs;
        logic need_wake;
        logic need_rst;
        logic wake_prev;
        logic rst_prev;
        logic last_bit;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic pin_toggle;
    logic expire;
    logic arm_rise;
    logic sleep_in;
    logic service;
    logic exit_now;
    logic tmr_clear, tmr_restart, tmr_run;
    wfs_mode_e mode;

    wfs_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (wd_pin_i),
        .toggle_o (pin_toggle)
    );

    wfs_timer #(.TIMEOUT(TIMEOUT), .SEL_W(SEL_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (tmr_clear),
        .restart_i  (tmr_restart),
        .run_i      (tmr_run),
        .div_load_i (div_load_i),
        .div_sel_i  (div_sel_i),
        .expire_o   (expire)
    );

    always_comb begin
        arm_rise = (wake_i && !st_q.wake_prev) || (ctl_rst_i && !st_q.rst_prev);
        sleep_in = !wake_i && !ctl_rst_i;
        service  = pin_toggle || (cmd_valid_i && (cmd_wd_bit_i != st_q.last_bit));
        exit_now = st_q.fs && !((st_q.need_wake && wake_i) || (st_q.need_rst && ctl_rst_i));

        tmr_clear   = st_q.fs || sleep_in || fs_disable_i;
        tmr_restart = arm_rise || (st_q.armed && service);
        tmr_run     = st_q.armed && !st_q.fs && !fs_disable_i;

        st_d           = st_q;
        st_d.wake_prev = wake_i;
        st_d.rst_prev  = ctl_rst_i;
        if (cmd_valid_i) st_d.last_bit = cmd_wd_bit_i;

        if (st_q.fs) begin
            if (exit_now) begin
                st_d.fs    = 1'b0;
                st_d.armed = wake_i || ctl_rst_i;
            end
        end else begin
            if (sleep_in)      st_d.armed = 1'b0;
            else if (arm_rise) st_d.armed = 1'b1;
            if (expire) begin
                st_d.fs        = 1'b1;
                st_d.need_wake = wake_i;
                st_d.need_rst  = ctl_rst_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.fs)        mode = MODE_FAILSAFE;
        else if (ctl_rst_i) mode = MODE_NORMAL;
        else if (wake_i)    mode = MODE_DEFAULT;
        else                mode = MODE_SLEEP;
    end

    always_comb begin
        unique case (mode)
            MODE_FAILSAFE: sw_en_o = FS_PAT;
            MODE_NORMAL:   sw_en_o = sw_req_i;
            default:       sw_en_o = '0;
        endcase
    end

    assign mode_o = mode;

    // R2
    fs_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fs) |-> $past(st_q.armed));

    // R10
    fsdis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_disable_i && !st_q.fs) |=> !st_q.fs);

    // R7
    fs_hold_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fs && st_q.need_wake && wake_i) |=> (mode_o == MODE_FAILSAFE));

    // R7
    fs_hold_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fs && st_q.need_rst && ctl_rst_i) |=> (mode_o == MODE_FAILSAFE));

    // R6
    fs_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_FAILSAFE) |-> (sw_en_o == FS_PAT));

    // R12
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP) |-> (sw_en_o == '0));

    // R12
    sleep_no_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_i && !ctl_rst_i && !st_q.fs) |=> !st_q.fs);

endmodule

// File: tb/tb_wdog_failsafe_ctrl.sv
module tb_wdog_failsafe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 32;
    localparam int NSW        = 12;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wake, crst, wdpin, cmd_valid, cmd_bit, div_load, fs_dis;
    logic [1:0]     div_sel;
    logic [NSW-1:0] sw_req;
    logic [NSW-1:0] sw_en;
    logic [1:0]     mode;

    int  n_checks = 0;
    int  n_fail   = 0;
    logic last_bit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_failsafe_ctrl #(.TIMEOUT(TMO)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_i       (wake),
        .ctl_rst_i    (crst),
        .wd_pin_i     (wdpin),
        .cmd_valid_i  (cmd_valid),
        .cmd_wd_bit_i (cmd_bit),
        .div_load_i   (div_load),
        .div_sel_i    (div_sel),
        .fs_disable_i (fs_dis),
        .sw_req_i     (sw_req),
        .sw_en_o      (sw_en),
        .mode_o       (mode)
    );

    function automatic logic [NSW-1:0] exp_en(input logic [1:0] m, input logic [NSW-1:0] req);
        case (m)
            2'd3:    return 12'h005;
            2'd2:    return req;
            default: return '0;
        endcase
    endfunction

    task automatic check_state(input string tag, input logic [1:0] m_exp);
        logic [NSW-1:0] e;
        e = exp_en(m_exp, sw_req);
        n_checks++;
        if (mode !== m_exp || sw_en !== e) begin
            n_fail++;
            $display("FAIL %s: actual mode=%0d en=%h expected mode=%0d en=%h",
                     tag, mode, sw_en, m_exp, e);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic b);
        cmd_valid = 1'b1;
        cmd_bit   = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        last_bit  = b;
    endtask

    // Ends one negedge after the restart edge; fail-safe due lim edges later
    task automatic expect_expiry(input string tag, input int lim, input logic [1:0] pre);
        wait_n(lim - 1);
        check_state(tag, pre);
        wait_n(1);
        check_state(tag, 2'd3);
    endtask

    task automatic to_sleep();
        wake = 1'b0;
        crst = 1'b0;
        wait_n(2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int g;
        void'($urandom(32'h1f2e3d4c));
        rst_n = 1'b0; wake = 0; crst = 0; wdpin = 0; cmd_valid = 0; cmd_bit = 0;
        div_load = 0; div_sel = 0; fs_dis = 0; sw_req = 12'hA5C;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state, R8 sleep code
        check_state("R1", 2'd0);

        // R2 arm by wake, R8 default code, R6 pattern on expiry
        wake = 1'b1; wait_n(1);
        check_state("R8", 2'd1);
        expect_expiry("R2", TMO, 2'd1);
        sw_req = 12'hFFF; wait_n(1);
        check_state("R6", 2'd3);
        // R7 rising control-reset in fail-safe is ignored; only wake recorded
        crst = 1'b1; wait_n(3);
        check_state("R7", 2'd3);
        wake = 1'b0; wait_n(1);
        check_state("R7", 2'd2);
        // R7 timer restarted at exit; R9 passthrough in normal
        sw_req = 12'h3C9;
        expect_expiry("R7", TMO, 2'd2);
        crst = 1'b0; wait_n(1);
        check_state("R7", 2'd0);

        // R7 both high at expiry: need both low
        wake = 1'b1; crst = 1'b1; wait_n(1);
        expect_expiry("R2", TMO, 2'd2);
        wake = 1'b0; wait_n(3);
        check_state("R7", 2'd3);
        crst = 1'b0; wait_n(1);
        check_state("R7", 2'd0);

        // R3 pin toggles on both edges
        crst = 1'b1; wait_n(1);
        wait_n(20);
        wdpin = 1'b1; wait_n(3);
        wait_n(20);
        check_state("R3", 2'd2);
        wdpin = 1'b0; wait_n(3);
        expect_expiry("R3", TMO, 2'd2);
        to_sleep();

        // R4 same-bit frame ignored
        crst = 1'b1; wait_n(1);
        wait_n(5);
        send_frame(last_bit);
        wait_n(TMO - 1 - 6);
        check_state("R4", 2'd2);
        wait_n(1);
        check_state("R4", 2'd3);
        to_sleep();
        // R4 flipped frame restarts
        crst = 1'b1; wait_n(1);
        wait_n(5);
        send_frame(~last_bit);
        expect_expiry("R4", TMO, 2'd2);
        to_sleep();

        // R5 divider values
        for (int s = 1; s <= 4; s++) begin
            crst = 1'b1; wait_n(1);
            div_sel = 2'(s % 4); div_load = 1'b1;
            @(negedge clk);
            div_load = 1'b0;
            expect_expiry("R5", TMO >> (s % 4), 2'd2);
            to_sleep();
        end

        // R10 disable blocks expiry
        fs_dis = 1'b1; crst = 1'b1;
        wait_n(3 * TMO);
        check_state("R10", 2'd2);
        fs_dis = 1'b0;
        expect_expiry("R10", TMO, 2'd2);
        to_sleep();

        // R11 service lands in the expiry cycle
        crst = 1'b1; wait_n(1);
        wait_n(TMO - 1);
        check_state("R11", 2'd2);
        send_frame(~last_bit);
        check_state("R11", 2'd2);
        expect_expiry("R11", TMO, 2'd2);
        send_frame(~last_bit);
        check_state("R11", 2'd3);
        to_sleep();

        // R12 sleep never expires
        crst = 1'b1; wait_n(20);
        crst = 1'b0; wait_n(3 * TMO);
        check_state("R12", 2'd0);

        // Random service gaps around the limit (R9, R2, R4)
        crst = 1'b1; wait_n(1);
        for (int i = 0; i < 40; i++) begin
            g = $urandom_range(TMO + 3, 1);
            sw_req = 12'($urandom);
            send_frame(~last_bit);
            wait_n(g);
            if (g < TMO) begin
                check_state("R9", 2'd2);
            end else begin
                check_state("R2", 2'd3);
                crst = 1'b0; wait_n(1);
                check_state("R7", 2'd0);
                crst = 1'b1; wait_n(1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule